// File: doc/BRIEF.md
# Serial Relay Register Loader

This block drives the shared control latch of a relay front end. The front end holds four 8-bit serial-in, parallel-out registers. Each register's output latch is clocked by one output of a 2-to-4 decoder. A command gives a register number, a data byte and a clear flag. For a load, the block shifts the byte out one bit at a time over a serial data line and a shift clock. It then lets the line settle and strobes the chosen register through the decoder. For a clear, the block skips shifting. It strobes the chosen register with the active-low clear line pulled low, which forces that register's outputs to zero.

The same latch also carries a transmit relay bit and a mute relay bit that belong to other logic. The block passes both through with one register of delay on every cycle, so no bus update disturbs them. Every bus phase lasts a programmable number of clock cycles, which lets slow board wiring settle. The busy output covers the whole command. A start that arrives while busy is dropped.

Top module: `srl_loader`

## Requirements
- R1: After reset the bus sits at its idle pattern: ser_data 0, shift_clk 0, sclr_n 1, dec_en_n 1, dec_sel 0, and busy 0.
- R2: A load shifts exactly 8 bits, most significant bit first. Each bit spends one phase on ser_data with shift_clk low. It then spends one phase with shift_clk high while ser_data holds the same value.
- R3: After the eighth bit, one settle phase follows with ser_data and shift_clk both low before the decoder is enabled.
- R4: The strobe phase drives dec_sel to the chosen register with dec_en_n at 0, while shift_clk and ser_data are 0. For a load, sclr_n stays 1. After the strobe the bus returns to the idle pattern, and dec_sel is 0 whenever dec_en_n is 1.
- R5: A clear produces no shift clock pulse. It drives a single strobe phase with sclr_n at 0, dec_en_n at 0 and dec_sel at the chosen register, and sclr_n is never 0 unless dec_en_n is 0.
- R6: During shift and settle phases, sclr_n is held at 1 and dec_en_n is held at 1.
- R7: tx_out and mute_out equal the tx_in and mute_in values of the previous cycle, on every cycle, including during commands.
- R8: Every bus phase lasts max(phase_len, 1) clock cycles. The length is sampled when the command is accepted.
- R9: busy rises on the clock edge that accepts start and falls on the edge that leaves the strobe phase. A load keeps busy high for 18 phases, and a clear keeps it high for 1 phase.
- R10: A start raised while busy is ignored. The running command completes with its own register, data and clear flag, and no second command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command request, taken only when idle |
| reg_sel | input | SEL_W | Target register number |
| wr_data | input | DATA_W | Byte to shift into the target register |
| clr_req | input | 1 | 1 = clear the target register instead of loading |
| phase_len | input | LEN_W | Cycles per bus phase, 0 treated as 1 |
| tx_in | input | 1 | Transmit relay bit to carry on the latch |
| mute_in | input | 1 | Mute relay bit to carry on the latch |
| ser_data | output | 1 | Serial data to the register chain |
| shift_clk | output | 1 | Shift clock |
| sclr_n | output | 1 | Active-low register clear |
| dec_en_n | output | 1 | Active-low decoder enable |
| dec_sel | output | SEL_W | Decoder select |
| tx_out | output | 1 | Transmit relay bit on the latch |
| mute_out | output | 1 | Mute relay bit on the latch |
| busy | output | 1 | Command in progress |

## Verification
The bench builds the block with its defaults: an 8-bit byte, a 2-bit select and a 4-bit phase length. It varies phase_len at run time across 0, 1, 2, 3 and 5. These values cover the zero-means-one rule, the shortest single-cycle phases and multi-cycle phases, where the shift clock width and the strobe width must stretch. Data patterns with a lone top bit, a lone bottom bit, alternating bits and all ones expose bit-order and count errors. A start poked in the middle of a load checks that a busy command cannot be overwritten.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHLO   = 3'd1,
        ST_SHHI   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_STROBE = 3'd4
    } step_e;

endpackage

// File: rtl/srl_phase_timer.sv
module srl_phase_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             last
);

    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        len_eff = (len == '0) ? LEN_W'(1) : len;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d = len_eff - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/srl_bus_encoder.sv
module srl_bus_encoder
    import srl_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  step_e            step,
    input  logic             bit_val,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             ser,
    output logic             sck,
    output logic             sclr_n,
    output logic             den_n,
    output logic [SEL_W-1:0] dsel
);

    always_comb begin
        ser    = 1'b0;
        sck    = 1'b0;
        sclr_n = 1'b1;
        den_n  = 1'b1;
        dsel   = '0;
        unique case (step)
            ST_SHLO: begin
                ser = bit_val;
            end
            ST_SHHI: begin
                ser = bit_val;
                sck = 1'b1;
            end
            ST_STROBE: begin
                den_n  = 1'b0;
                dsel   = sel;
                sclr_n = !clr;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/srl_loader.sv
module srl_loader
    import srl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_req,
    input  logic [LEN_W-1:0]  phase_len,
    input  logic              tx_in,
    input  logic              mute_in,
    output logic              ser_data,
    output logic              shift_clk,
    output logic              sclr_n,
    output logic              dec_en_n,
    output logic [SEL_W-1:0]  dec_sel,
    output logic              tx_out,
    output logic              mute_out,
    output logic              busy
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        step_e             step;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] dat;
        logic [SEL_W-1:0]  sel;
        logic              clr;
        logic [LEN_W-1:0]  len;
        logic              busy;
        logic              tx;
        logic              mute;
    } ctl_t;

    typedef struct packed {
        logic             ser;
        logic             sck;
        logic             sclr_n;
        logic             den_n;
        logic [SEL_W-1:0] dsel;
    } pin_t;

    ctl_t ctl_d, ctl_q;
    pin_t pin_d, pin_q;
    logic load;
    logic last;

    srl_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .len   (ctl_d.len),
        .last  (last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        load       = 1'b0;
        ctl_d.tx   = tx_in;
        ctl_d.mute = mute_in;
        unique case (ctl_q.step)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.sel  = reg_sel;
                    ctl_d.dat  = wr_data;
                    ctl_d.clr  = clr_req;
                    ctl_d.len  = phase_len;
                    ctl_d.bidx = IDX_W'(DATA_W - 1);
                    ctl_d.step = clr_req ? ST_STROBE : ST_SHLO;
                    load       = 1'b1;
                end
            end
            ST_SHLO: begin
                if (last) begin
                    ctl_d.step = ST_SHHI;
                    load       = 1'b1;
                end
            end
            ST_SHHI: begin
                if (last) begin
                    load = 1'b1;
                    if (ctl_q.bidx == '0) begin
                        ctl_d.step = ST_SETTLE;
                    end else begin
                        ctl_d.bidx = ctl_q.bidx - 1'b1;
                        ctl_d.step = ST_SHLO;
                    end
                end
            end
            ST_SETTLE: begin
                if (last) begin
                    ctl_d.step = ST_STROBE;
                    load       = 1'b1;
                end
            end
            ST_STROBE: begin
                if (last) begin
                    ctl_d.step = ST_IDLE;
                end
            end
            default: begin
                ctl_d.step = ST_IDLE;
            end
        endcase
        ctl_d.busy = (ctl_d.step != ST_IDLE);
    end

    srl_bus_encoder #(.SEL_W(SEL_W)) u_enc (
        .step    (ctl_d.step),
        .bit_val (ctl_d.dat[ctl_d.bidx]),
        .sel     (ctl_d.sel),
        .clr     (ctl_d.clr),
        .ser     (pin_d.ser),
        .sck     (pin_d.sck),
        .sclr_n  (pin_d.sclr_n),
        .den_n   (pin_d.den_n),
        .dsel    (pin_d.dsel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{step: ST_IDLE, default: '0};
            pin_q <= '{ser: 1'b0, sck: 1'b0, sclr_n: 1'b1, den_n: 1'b1, dsel: '0};
        end else begin
            ctl_q <= ctl_d;
            pin_q <= pin_d;
        end
    end

    assign ser_data  = pin_q.ser;
    assign shift_clk = pin_q.sck;
    assign sclr_n    = pin_q.sclr_n;
    assign dec_en_n  = pin_q.den_n;
    assign dec_sel   = pin_q.dsel;
    assign tx_out    = ctl_q.tx;
    assign mute_out  = ctl_q.mute;
    assign busy      = ctl_q.busy;

    AST_SCLR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !sclr_n |-> !dec_en_n); // R5
    AST_QUIET_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en_n |-> (!shift_clk && !ser_data)); // R4
    AST_SER_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> $stable(ser_data)); // R2
    AST_SEL_ZERO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en_n |-> (dec_sel == '0)); // R4
    AST_BUSY_ENDS_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!dec_en_n)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ctl_q.sel) && $stable(ctl_q.dat) && $stable(ctl_q.clr))); // R10
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_out == $past(tx_in) && mute_out == $past(mute_in))); // R7

endmodule

// File: tb/srl_loader_tb.sv
module srl_loader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] wr_data = '0;
    logic       clr_req = 1'b0;
    logic [3:0] phase_len = 4'd1;
    logic       tx_in = 1'b0;
    logic       mute_in = 1'b0;
    logic       ser_data, shift_clk, sclr_n, dec_en_n, tx_out, mute_out, busy;
    logic [1:0] dec_sel;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    srl_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_sel(reg_sel),
        .wr_data(wr_data), .clr_req(clr_req), .phase_len(phase_len),
        .tx_in(tx_in), .mute_in(mute_in), .ser_data(ser_data),
        .shift_clk(shift_clk), .sclr_n(sclr_n), .dec_en_n(dec_en_n),
        .dec_sel(dec_sel), .tx_out(tx_out), .mute_out(mute_out), .busy(busy)
    );

    typedef struct {
        logic [1:0] sel;
        logic [7:0] dat;
        logic       clr;
        int         n;
    } exp_t;

    exp_t exp_q[$];
    int   ops_pushed = 0;
    int   ops_done = 0;
    int   pass_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // pass-through bits change a little after each rising edge
    initial begin
        logic [7:0] lf = 8'h5B;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            tx_in = lf[0];
            mute_in = lf[3];
        end
    end

    // monitor: samples on falling edges
    bit         in_op = 0;
    int         busy_cnt, nbits, sck_run, strobe_cnt;
    logic [7:0] bits;
    bit         sck_bad, hold_bad, r6_bad, settle_ok, settle_seen, strobe_sel_bad;
    logic [1:0] strobe_sel;
    logic       strobe_sclr;
    logic       p_ser = 0, p_sck = 0, p_en_n = 1, p_tx = 0, p_mute = 0;
    bit         p_valid = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_valid && (tx_out !== p_tx || mute_out !== p_mute)) pass_bad++;
            if (busy) begin
                if (!in_op) begin
                    in_op = 1; busy_cnt = 0; nbits = 0; bits = '0; sck_run = 0;
                    strobe_cnt = 0; sck_bad = 0; hold_bad = 0; r6_bad = 0;
                    settle_ok = 0; settle_seen = 0; strobe_sel_bad = 0;
                    strobe_sel = '0; strobe_sclr = 1'b1;
                end
                busy_cnt++;
                if (shift_clk && !p_sck) begin
                    nbits++;
                    bits = {bits[6:0], ser_data};
                    sck_run = 1;
                    if (ser_data !== p_ser) hold_bad = 1;
                end else if (shift_clk) begin
                    sck_run++;
                end
                if (!shift_clk && p_sck && exp_q.size() > 0 && sck_run != exp_q[0].n) sck_bad = 1;
                if (!dec_en_n) begin
                    if (p_en_n) begin
                        settle_seen = 1;
                        settle_ok = (!p_ser && !p_sck);
                        strobe_sel = dec_sel;
                        strobe_sclr = sclr_n;
                    end else if (dec_sel !== strobe_sel || sclr_n !== strobe_sclr) begin
                        strobe_sel_bad = 1;
                    end
                    strobe_cnt++;
                end else if (!sclr_n) begin
                    r6_bad = 1;
                end
            end else if (in_op) begin
                exp_t e;
                in_op = 0;
                ops_done++;
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected command", ops_done, ops_pushed);
                end else begin
                    e = exp_q.pop_front();
                    check(busy_cnt == (e.clr ? e.n : 18 * e.n), "R9", "busy cycles",
                          busy_cnt, e.clr ? e.n : 18 * e.n);
                    check(strobe_cnt == e.n, "R8", "strobe cycles", strobe_cnt, e.n);
                    check(strobe_sel == e.sel && !strobe_sel_bad, "R4", "strobe select",
                          strobe_sel, e.sel);
                    check(!r6_bad, "R6", "clear outside strobe", r6_bad, 0);
                    check(dec_en_n && sclr_n && dec_sel == 2'd0 && !shift_clk && !ser_data,
                          "R4", "idle after strobe", {dec_en_n, sclr_n, dec_sel}, 6'b1100);
                    if (e.clr) begin
                        check(nbits == 0, "R5", "shift pulses on clear", nbits, 0);
                        check(strobe_sclr == 1'b0, "R5", "sclr_n in clear strobe", strobe_sclr, 0);
                    end else begin
                        check(nbits == 8, "R2", "bit count", nbits, 8);
                        check(bits == e.dat, "R2", "shifted byte", bits, e.dat);
                        check(!hold_bad, "R2", "data held at clock rise", hold_bad, 0);
                        check(!sck_bad, "R8", "shift clock high width", sck_bad, 0);
                        check(settle_seen && settle_ok, "R3", "settle before strobe", settle_ok, 1);
                        check(strobe_sclr == 1'b1, "R4", "sclr_n in load strobe", strobe_sclr, 1);
                    end
                end
            end
            p_valid = 1;
        end
        p_ser = ser_data; p_sck = shift_clk; p_en_n = dec_en_n;
        p_tx = tx_in; p_mute = mute_in;
    end

    task automatic do_op(input logic [1:0] s, input logic [7:0] d, input logic c,
                         input logic [3:0] len, input bit poke);
        exp_t e;
        while (busy) @(posedge clk);
        @(posedge clk);
        #1;
        reg_sel = s; wr_data = d; clr_req = c; phase_len = len; start = 1'b1;
        e.sel = s; e.dat = d; e.clr = c; e.n = (len == 0) ? 1 : int'(len);
        exp_q.push_back(e);
        ops_pushed++;
        @(posedge clk);
        #1;
        start = 1'b0;
        if (poke) begin
            repeat (4) @(posedge clk);
            #1;
            reg_sel = ~s; wr_data = ~d; clr_req = 1'b1; phase_len = 4'd7; start = 1'b1;
            @(posedge clk);
            #1;
            start = 1'b0;
        end
        while (busy) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!ser_data && !shift_clk && sclr_n && dec_en_n && dec_sel == 2'd0 && !busy,
              "R1", "reset pattern", {ser_data, shift_clk, sclr_n, dec_en_n, dec_sel, busy},
              7'b0011000);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(dec_en_n && sclr_n && !busy, "R1", "idle after reset release",
              {dec_en_n, sclr_n, busy}, 3'b110);

        do_op(2'd2, 8'hA5, 1'b0, 4'd1, 0);
        do_op(2'd1, 8'h3C, 1'b0, 4'd3, 0);
        do_op(2'd3, 8'h80, 1'b0, 4'd0, 0);
        do_op(2'd0, 8'h00, 1'b1, 4'd2, 0);
        do_op(2'd0, 8'h01, 1'b0, 4'd2, 1);   // R10 poke during load
        do_op(2'd3, 8'h55, 1'b1, 4'd1, 0);
        do_op(2'd1, 8'hFF, 1'b0, 4'd5, 0);

        repeat (20) @(posedge clk);
        @(negedge clk);
        check(!busy && ops_done == ops_pushed, "R10", "no extra command after poke",
              ops_done, ops_pushed);
        check(pass_bad == 0, "R7", "tx/mute pass-through mismatches", pass_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule